// File: doc/BRIEF.md
# Sticky Status Register Bank

This block is a small bank of status registers reached over a plain single-cycle bus slave port: an address, a write strobe with write data, and a read strobe whose answer comes back one clock later, flagged by a read-valid pulse. It holds two families of registers, and each family is replicated by a parameter.

The first family captures hardware event flags. Any event bit that arrives is ORed into the register and stays there. The register empties itself when software reads its word. An event that arrives in the same cycle as that read is not lost. The second family holds flags that software raises by writing ones. Hardware can drop them through a dedicated clear input, and their current value is driven out to the surrounding logic.

Every register is a field of configurable width. Its placement is set by parameters: a bus address, and the bit offset of its least significant bit inside the data word. Several fields may share one word. Bits that no field covers, and addresses that no field uses, read back as zero.

Top module: `stsreg_bank`

## Requirements
- R1: A synchronous active-high reset clears every event register, every software-set register, `set_q`, `bus_rdata` and `bus_rvalid` to zero.
- R2: Outside a clearing read, each event register updates on every clock to the OR of its current value and its `evt_in` slice. A bit that has been set stays set.
- R3: A read whose address equals an event register's address returns that register's current value, and clears the register on the same clock edge. With no new events, a second read returns zero.
- R4: If an event bit is present in the same cycle as the clearing read, the register's next value is that cycle's event bits rather than zero.
- R5: A write whose address equals a software-set register's address sets each register bit `k` for which write-data bit `offset+k` is 1.
- R6: Write-data bits that are 0 leave the corresponding software-set register bits unchanged.
- R7: A 1 on a `set_clr` bit clears that software-set register bit. If a write sets the same bit in the same cycle, the bit ends up set.
- R8: `bus_rvalid` is high in exactly the cycle after a cycle with `bus_rd` high. `bus_rdata` carries the read word in that cycle and is zero whenever `bus_rvalid` is low.
- R9: Read-data bits outside every field mapped at the read address are zero. A read of an address with no mapped field returns all zeros.
- R10: Writes to an event register's address do not change that register.
- R11: Each software-set register reads back at its address and offset, and its value is continuously driven on its slice of `set_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word address for reads and writes |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read-valid pulse, one cycle after `bus_rd` |
| evt_in | input | NUM_EVT*EVT_W | Event bits, slice i feeds event register i |
| set_clr | input | NUM_SET*SET_W | Hardware clear bits, slice i clears software-set register i |
| set_q | output | NUM_SET*SET_W | Current value of the software-set registers |

## Verification
The bench builds the bank with two 8-bit event registers and two 8-bit software-set registers in a 32-bit word. One event field sits at offset 0 of address 0x00. The other sits at offset 24 of address 0x04, which puts its top bit on the word's last bit. Both software-set fields share address 0x08, at offsets 0 and 16. With this layout, one write touches two fields at once, the unmapped gaps between fields are readable, and field placement at the word's upper edge is exercised. Reads of 0x0C and 0x40 cover addresses with no field.

// File: rtl/stsreg_pkg.sv
package stsreg_pkg;

  // Widest bus word the placement helpers support.
  localparam int unsigned MAX_DW = 64;

  typedef logic [MAX_DW-1:0] wide_word_t;

  // Move a right-aligned field value up to bit position ofs of a word.
  function automatic wide_word_t place(input wide_word_t v, input int unsigned ofs);
    return v << ofs;
  endfunction

  // Bring the field that starts at bit ofs down to bit 0.
  function automatic wide_word_t pick(input wide_word_t w, input int unsigned ofs);
    return w >> ofs;
  endfunction

endpackage

// File: rtl/stsreg_sticky.sv
module stsreg_sticky #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned W      = 8,
  parameter int unsigned ADDR   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic [W-1:0]      evt,
  output logic [W-1:0]      q
);

  logic rd_hit;
  assign rd_hit = rd && (addr == ADDR_W'(ADDR));

  // On a clearing read the value is replaced by the events of this cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (rd_hit) begin
      q <= evt;
    end else begin
      q <= q | evt;
    end
  end

  assert_sticky_keep_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> ((q & $past(q)) == $past(q)));

  assert_clear_on_read_R3: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> ((q & ~$past(evt)) == '0));

  assert_race_event_kept_R4: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> ((q & $past(evt)) == $past(evt)));

endmodule

// File: rtl/stsreg_setreg.sv
module stsreg_setreg #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned W      = 8,
  parameter int unsigned ADDR   = 8,
  parameter int unsigned OFS    = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [W-1:0]      clr,
  output logic [W-1:0]      q
);
  import stsreg_pkg::*;

  logic         wr_hit;
  logic [W-1:0] wfield;
  logic [W-1:0] wset;

  assign wr_hit = wr && (addr == ADDR_W'(ADDR));
  assign wfield = W'(pick(MAX_DW'(wdata), OFS));
  assign wset   = wr_hit ? wfield : '0;

  // Set is applied after clear, so a write-one beats a same-cycle clear.
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      q <= (q & ~clr) | wset;
    end
  end

  // R5, and R7: written ones are present afterwards, whatever clr was
  assert_write_one_sets_R5: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> ((q & $past(wfield)) == $past(wfield)));

  assert_write_zero_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (clr == '0) |=> ((q & $past(q)) == $past(q)));

  assert_hw_clear_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> ((q & $past(clr)) == '0));

endmodule

// File: rtl/stsreg_rdmux.sv
module stsreg_rdmux #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned EVT_W   = 8,
  parameter int unsigned SET_W   = 8,
  parameter int unsigned NUM_EVT = 2,
  parameter int unsigned NUM_SET = 2,
  parameter int unsigned EVT_ADDR [NUM_EVT] = '{0, 4},
  parameter int unsigned EVT_OFS  [NUM_EVT] = '{0, 0},
  parameter int unsigned SET_ADDR [NUM_SET] = '{8, 12},
  parameter int unsigned SET_OFS  [NUM_SET] = '{0, 0}
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     rd,
  input  logic [NUM_EVT*EVT_W-1:0] evt_q,
  input  logic [NUM_SET*SET_W-1:0] set_q,
  output logic [DATA_W-1:0]        rdata,
  output logic                     rvalid
);
  import stsreg_pkg::*;

  logic [DATA_W-1:0] word;
  logic              any_hit;

  always_comb begin
    word    = '0;
    any_hit = 1'b0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (addr == ADDR_W'(EVT_ADDR[i])) begin
        word    = word | DATA_W'(place(MAX_DW'(evt_q[i*EVT_W +: EVT_W]), EVT_OFS[i]));
        any_hit = 1'b1;
      end
    end
    for (int j = 0; j < NUM_SET; j++) begin
      if (addr == ADDR_W'(SET_ADDR[j])) begin
        word    = word | DATA_W'(place(MAX_DW'(set_q[j*SET_W +: SET_W]), SET_OFS[j]));
        any_hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rdata  <= rd ? word : '0;
      rvalid <= rd;
    end
  end

  assert_rvalid_follows_R8: assert property (@(posedge clk) disable iff (rst)
    rd |=> rvalid);

  assert_rvalid_only_after_rd_R8: assert property (@(posedge clk) disable iff (rst)
    !rd |=> !rvalid);

  assert_rdata_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !rvalid |-> (rdata == '0));

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rd && !any_hit) |=> (rdata == '0));

endmodule

// File: rtl/stsreg_bank.sv
module stsreg_bank #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned EVT_W   = 8,
  parameter int unsigned SET_W   = 8,
  parameter int unsigned NUM_EVT = 2,
  parameter int unsigned NUM_SET = 2,
  parameter int unsigned EVT_ADDR [NUM_EVT] = '{0, 4},
  parameter int unsigned EVT_OFS  [NUM_EVT] = '{0, 0},
  parameter int unsigned SET_ADDR [NUM_SET] = '{8, 12},
  parameter int unsigned SET_OFS  [NUM_SET] = '{0, 0}
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic [DATA_W-1:0]        bus_wdata,
  input  logic                     bus_rd,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic                     bus_rvalid,
  input  logic [NUM_EVT*EVT_W-1:0] evt_in,
  input  logic [NUM_SET*SET_W-1:0] set_clr,
  output logic [NUM_SET*SET_W-1:0] set_q
);

  localparam int unsigned EVT_BITS = NUM_EVT * EVT_W;

  logic [EVT_BITS-1:0] evt_q;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    stsreg_sticky #(
      .ADDR_W(ADDR_W),
      .W     (EVT_W),
      .ADDR  (EVT_ADDR[i])
    ) u_stk (
      .clk (clk),
      .rst (rst),
      .addr(bus_addr),
      .rd  (bus_rd),
      .evt (evt_in[i*EVT_W +: EVT_W]),
      .q   (evt_q[i*EVT_W +: EVT_W])
    );
  end

  for (genvar j = 0; j < NUM_SET; j++) begin : g_set
    stsreg_setreg #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .W     (SET_W),
      .ADDR  (SET_ADDR[j]),
      .OFS   (SET_OFS[j])
    ) u_set (
      .clk  (clk),
      .rst  (rst),
      .addr (bus_addr),
      .wr   (bus_wr),
      .wdata(bus_wdata),
      .clr  (set_clr[j*SET_W +: SET_W]),
      .q    (set_q[j*SET_W +: SET_W])
    );
  end

  stsreg_rdmux #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .EVT_W   (EVT_W),
    .SET_W   (SET_W),
    .NUM_EVT (NUM_EVT),
    .NUM_SET (NUM_SET),
    .EVT_ADDR(EVT_ADDR),
    .EVT_OFS (EVT_OFS),
    .SET_ADDR(SET_ADDR),
    .SET_OFS (SET_OFS)
  ) u_rd (
    .clk   (clk),
    .rst   (rst),
    .addr  (bus_addr),
    .rd    (bus_rd),
    .evt_q (evt_q),
    .set_q (set_q),
    .rdata (bus_rdata),
    .rvalid(bus_rvalid)
  );

  // R1: reset leaves the read port silent
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!bus_rvalid && (bus_rdata == '0) && (set_q == '0)));

endmodule

// File: tb/sim_stsreg_bank.sv
module sim_stsreg_bank;

  localparam int unsigned EA [2] = '{'h00, 'h04};
  localparam int unsigned EO [2] = '{0, 24};
  localparam int unsigned SA [2] = '{'h08, 'h08};
  localparam int unsigned SO [2] = '{0, 16};

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic        bus_rd;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [15:0] evt_in;
  logic [15:0] set_clr;
  logic [15:0] set_q;

  always #4 clk = ~clk;

  stsreg_bank #(
    .ADDR_W(8), .DATA_W(32), .EVT_W(8), .SET_W(8), .NUM_EVT(2), .NUM_SET(2),
    .EVT_ADDR(EA), .EVT_OFS(EO), .SET_ADDR(SA), .SET_OFS(SO)
  ) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .evt_in(evt_in), .set_clr(set_clr), .set_q(set_q)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string cur_req = "R1";

  logic [7:0]  m_stk [2];
  logic [7:0]  m_set [2];
  logic        exp_rv;
  logic [31:0] exp_rd;

  function automatic logic [31:0] model_word(input logic [7:0] a);
    logic [31:0] w = '0;
    for (int i = 0; i < 2; i++) begin
      if (a == 8'(EA[i])) w |= {24'h0, m_stk[i]} << EO[i];
      if (a == 8'(SA[i])) w |= {24'h0, m_set[i]} << SO[i];
    end
    return w;
  endfunction

  // Next-state of the reference, computed from the inputs held over the coming edge.
  task automatic model_next();
    if (rst) begin
      for (int i = 0; i < 2; i++) begin
        m_stk[i] = '0;
        m_set[i] = '0;
      end
      exp_rv = 1'b0;
      exp_rd = '0;
    end else begin
      exp_rv = bus_rd;
      exp_rd = bus_rd ? model_word(bus_addr) : 32'h0;
      for (int i = 0; i < 2; i++) begin
        logic [7:0] ev, cl, ws;
        ev = evt_in[i*8 +: 8];
        cl = set_clr[i*8 +: 8];
        ws = (bus_wr && bus_addr == 8'(SA[i])) ? 8'(bus_wdata >> SO[i]) : 8'h00;
        if (bus_rd && bus_addr == 8'(EA[i])) m_stk[i] = ev;
        else m_stk[i] = m_stk[i] | ev;
        m_set[i] = (m_set[i] & ~cl) | ws;
      end
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    model_next();
    @(posedge clk);
    #1;
    chk("R8", {31'h0, bus_rvalid}, {31'h0, exp_rv});
    chk(cur_req, bus_rdata, exp_rd);
    chk((cur_req == "R1") ? "R1" : "R11", {16'h0, set_q}, {16'h0, m_set[1], m_set[0]});
  endtask

  task automatic cyc(input logic [7:0] a, input logic w, input logic [31:0] d,
                     input logic r, input logic [15:0] e, input logic [15:0] c);
    bus_addr  = a;
    bus_wr    = w;
    bus_wdata = d;
    bus_rd    = r;
    evt_in    = e;
    set_clr   = c;
    tick();
  endtask

  task automatic idle();      cyc(8'h00, 1'b0, 32'h0, 1'b0, 16'h0, 16'h0); endtask
  task automatic rd(input logic [7:0] a); cyc(a, 1'b0, 32'h0, 1'b1, 16'h0, 16'h0); endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d); cyc(a, 1'b1, d, 1'b0, 16'h0, 16'h0); endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL R8: watchdog expired (actual hung, expected finished)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    bus_addr = '0; bus_wr = 0; bus_wdata = '0; bus_rd = 0; evt_in = '0; set_clr = '0;
    // R1: reset state, then every register reads zero
    cur_req = "R1";
    repeat (3) tick();
    rst = 1'b0;
    rd(8'h00); rd(8'h04); rd(8'h08); idle();

    // R2: events in separate cycles accumulate and stay
    cur_req = "R2";
    cyc(8'h00, 0, 0, 0, 16'h0001, 0);
    cyc(8'h00, 0, 0, 0, 16'h0010, 0);
    cyc(8'h00, 0, 0, 0, 16'h8000, 0);
    idle(); idle();
    rd(8'h00); rd(8'h04); idle();

    // R3: a read empties the register
    cur_req = "R3";
    cyc(8'h00, 0, 0, 0, 16'h4221, 0);
    rd(8'h00); rd(8'h00); rd(8'h04); rd(8'h04); idle();

    // R4: event concurrent with the clearing read is kept
    cur_req = "R4";
    cyc(8'h00, 0, 0, 0, 16'h00F0, 0);
    cyc(8'h00, 0, 0, 1, 16'h000F, 0);
    idle(); rd(8'h00);
    cyc(8'h04, 0, 0, 1, 16'h8100, 0);
    rd(8'h04); rd(8'h04); idle();

    // R5: write ones to both fields of the shared word
    cur_req = "R5";
    wr(8'h08, 32'h00A5_0081);
    rd(8'h08); idle();
    wr(8'h08, 32'h0002_0040);
    rd(8'h08); idle();

    // R6: zeros in the write data change nothing
    cur_req = "R6";
    wr(8'h08, 32'h0);
    rd(8'h08);
    wr(8'h08, 32'hFF00_FF00);
    rd(8'h08); idle();

    // R7: hardware clear, and set beating a same-cycle clear
    cur_req = "R7";
    cyc(8'h00, 0, 0, 0, 0, 16'h00FF);
    rd(8'h08);
    cyc(8'h08, 1, 32'h0000_003C, 0, 0, 16'h003C);
    rd(8'h08);
    cyc(8'h08, 1, 32'h0001_0000, 0, 0, 16'hFFFF);
    rd(8'h08); idle();

    // R8: back-to-back reads and a read/idle mix
    cur_req = "R8";
    rd(8'h08); rd(8'h08); idle(); rd(8'h08); idle(); idle();

    // R9: unmapped addresses and gaps between fields
    cur_req = "R9";
    cyc(8'h00, 0, 0, 0, 16'hFFFF, 0);
    rd(8'h0C); rd(8'h40); rd(8'h04); rd(8'h00); idle();

    // R10: writes aimed at event registers are ignored
    cur_req = "R10";
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h00); rd(8'h04); idle();

    // R11: mixed random traffic, set_q tracked every cycle
    cur_req = "R11";
    for (int n = 0; n < 400; n++) begin
      logic [7:0] a;
      case ($urandom_range(0, 4))
        0: a = 8'h00;
        1: a = 8'h04;
        2: a = 8'h08;
        3: a = 8'h0C;
        default: a = 8'h40;
      endcase
      cyc(a, 1'($urandom_range(0, 1)), $urandom, 1'($urandom_range(0, 1)),
          16'($urandom) & 16'($urandom) & 16'($urandom),
          16'($urandom) & 16'($urandom) & 16'($urandom));
    end
    idle();

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule